// File: doc/BRIEF.md
# Timer Capture Channel Input Front-End

This block forms the receiving side of one capture/compare channel inside a motor-control timer. It synchronizes the channel's external pins to the timer clock and builds the channel's own input: either pin 0 alone, or the XOR of pins 0, 1 and 2. The XOR form suits three hall-sensor lines, because any sensor transition then toggles one combined signal. A mode field then chooses what feeds the capture path: the channel's own input, the neighbouring channel's pin, or an edge signal from the trigger controller.

Rising edges of the chosen signal count as events. A prescaler passes on every 1st, 2nd, 4th or 8th event as a single-cycle capture strobe to the counter logic outside this block. The block holds one 32-bit configuration word with a plain write strobe and a combinational read-back. The channel-enable input does two things: it write-protects the mode field, and it clears the prescaler when it is low.

Top module: `capchan_frontend`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 0x0000_0000, `ch_mode_o` is 00 and `cap_stb_o` is low.
- R2: Only bit 31 (source select), bits [19:18] (prescale code) and bits [17:16] (mode) are stored. Every other bit of `cfg_rdata_o` reads 0, whatever value was written.
- R3: With bit 31 = 0, the channel's own input is pin 0. Transitions on pins 1 and 2 then produce no strobe in mode 01.
- R4: With bit 31 = 1, the channel's own input is pin0 XOR pin1 XOR pin2. A rising transition of that XOR on any single pin is an event.
- R5: Prescale code 00, 01, 10 or 11 makes a strobe on every 1st, 2nd, 4th or 8th rising event respectively. After the strobe the event count restarts from zero.
- R6: While `chan_en_i` is low, the prescaler event count is held at zero. Events counted before a disable do not carry over into the next enable.
- R7: A write while `chan_en_i` is high leaves the mode field unchanged, both in `cfg_rdata_o` and in `ch_mode_o`. The other fields are still written.
- R8: Mode 01 takes the channel's own input, mode 10 takes pin 1, and mode 11 takes `trig_edge_i`. Mode 00 marks the channel as an output, and `ch_mode_o` always shows the mode field.
- R9: No strobe appears in the cycle after one in which `chan_en_i` is low or the mode is 00.
- R10: `cap_stb_o` is never high for two consecutive cycles.
- R11: A pin that rises just before clock edge k passes two synchronizer flops. `cap_stb_o` for that event is then high in the cycle after edge k+2. Pins are sampled only through this path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS (3) | Asynchronous channel pins 0..2 |
| trig_edge_i | input | 1 | Edge signal from the trigger controller, synchronous to clk |
| chan_en_i | input | 1 | Channel enable; locks the mode field and releases the prescaler |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read-back |
| cap_stb_o | output | 1 | Single-cycle capture strobe |
| ch_mode_o | output | 2 | Current mode field (00 output, 01 own input, 10 neighbour pin, 11 trigger edge) |

## Verification
The bench builds the block with its default parameters: three pins, a two-flop synchronizer and a two-bit prescale code. With these values the 3-cycle pin-to-strobe latency, the full XOR input and the divide-by-8 limit can all be reached with short pin pulse trains. A behavioural model written per clock tracks the pin delay line, the previous selected level and the event count. The bench compares this model against the strobe, the mode output and the read-back on every cycle. Directed strobe counts cover each prescale code, XOR sourcing, write protection and the prescaler clear on disable.

// File: rtl/capfe_pkg.sv
package capfe_pkg;
   localparam int REG_W    = 32;
   localparam int SRC_POS  = 31;
   localparam int PSC_W    = 2;
   localparam int PSC_LSB  = 18;
   localparam int MODE_W   = 2;
   localparam int MODE_LSB = 16;

   typedef enum logic [MODE_W-1:0] {
      CH_OUT      = 2'b00,
      CH_IN_OWN   = 2'b01,
      CH_IN_NEIGH = 2'b10,
      CH_IN_TRIG  = 2'b11
   } ch_mode_e;
endpackage

// File: rtl/capfe_sync.sv
module capfe_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/capfe_cfg.sv
module capfe_cfg
   import capfe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic             chan_en,
   output logic             src_xor,
   output logic [PSC_W-1:0] psc,
   output ch_mode_e         mode,
   output logic [REG_W-1:0] rdata
);
   logic unused_wbits;
   assign unused_wbits = ^{wdata[SRC_POS-1:PSC_LSB+PSC_W], wdata[MODE_LSB-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_xor <= 1'b0;
         psc     <= '0;
         mode    <= CH_OUT;
      end else if (we) begin
         src_xor <= wdata[SRC_POS];
         psc     <= wdata[PSC_LSB +: PSC_W];
         if (!chan_en) mode <= ch_mode_e'(wdata[MODE_LSB +: MODE_W]);
      end
   end

   always_comb begin
      rdata                      = '0;
      rdata[SRC_POS]             = src_xor;
      rdata[PSC_LSB +: PSC_W]    = psc;
      rdata[MODE_LSB +: MODE_W]  = mode;
   end
endmodule

// File: rtl/capfe_sel.sv
module capfe_sel
   import capfe_pkg::*;
#(
   parameter int NUM_PINS = 3
) (
   input  logic [NUM_PINS-1:0] pins,
   input  logic                trig,
   input  logic                src_xor,
   input  ch_mode_e            mode,
   output logic                sel
);
   logic own_in;

   assign own_in = src_xor ? (^pins) : pins[0];

   always_comb begin
      unique case (mode)
         CH_IN_OWN:   sel = own_in;
         CH_IN_NEIGH: sel = pins[1];
         CH_IN_TRIG:  sel = trig;
         default:     sel = 1'b0;
      endcase
   end
endmodule

// File: rtl/capfe_psc.sv
module capfe_psc #(
   parameter int PSC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             clr,
   input  logic             active,
   input  logic [PSC_W-1:0] psc,
   output logic             stb
);
   localparam int CODES = 1 << PSC_W;
   localparam int CNT_W = (CODES > 1) ? CODES - 1 : 1;

   logic             prev;
   logic             rise;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             at_limit;

   always_comb begin
      limit = '0;
      for (int i = 0; i < CODES; i++)
         if (psc == PSC_W'(i)) limit = CNT_W'((1 << i) - 1);
   end

   assign rise     = sel & ~prev;
   assign at_limit = (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         cnt  <= '0;
         stb  <= 1'b0;
      end else begin
         prev <= sel;
         stb  <= ~clr & active & rise & at_limit;
         if (clr)                 cnt <= '0;
         else if (active && rise) cnt <= at_limit ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/capchan_frontend.sv
module capchan_frontend
   import capfe_pkg::*;
#(
   parameter int NUM_PINS    = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit PIN_SYNC    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                trig_edge_i,
   input  logic                chan_en_i,
   input  logic                cfg_we_i,
   input  logic [REG_W-1:0]    cfg_wdata_i,
   output logic [REG_W-1:0]    cfg_rdata_o,
   output logic                cap_stb_o,
   output logic [MODE_W-1:0]   ch_mode_o
);
   if (NUM_PINS < 2) begin : g_bad_pins
      $error("capchan_frontend: NUM_PINS must be at least 2");
   end
   if (PIN_SYNC && SYNC_STAGES < 2) begin : g_bad_sync
      $error("capchan_frontend: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] pins_s;
   logic                src_xor;
   logic [PSC_W-1:0]    psc;
   ch_mode_e            mode;
   logic                sel;
   logic                active;

   if (PIN_SYNC) begin : g_sync
      capfe_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pin_i),
         .q     (pins_s)
      );
   end else begin : g_nosync
      assign pins_s = pin_i;
   end

   capfe_cfg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we_i),
      .wdata   (cfg_wdata_i),
      .chan_en (chan_en_i),
      .src_xor (src_xor),
      .psc     (psc),
      .mode    (mode),
      .rdata   (cfg_rdata_o)
   );

   capfe_sel #(.NUM_PINS(NUM_PINS)) u_sel (
      .pins    (pins_s),
      .trig    (trig_edge_i),
      .src_xor (src_xor),
      .mode    (mode),
      .sel     (sel)
   );

   assign active = chan_en_i & (mode != CH_OUT);

   capfe_psc #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .clr    (~chan_en_i),
      .active (active),
      .psc    (psc),
      .stb    (cap_stb_o)
   );

   assign ch_mode_o = mode;
endmodule

// File: rtl/capfe_chk.sv
module capfe_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       chan_en,
   input logic       stb,
   input logic [1:0] mode
);
   // R10
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> !stb);

   // R9
   no_stb_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !stb);

   // R9
   no_stb_outmode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=> !stb);

   // R7
   mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en |=> $stable(mode));
endmodule

bind capchan_frontend capfe_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .chan_en (chan_en_i),
   .stb     (cap_stb_o),
   .mode    (ch_mode_o)
);

// File: tb/tb_capchan_frontend.sv
module tb_capchan_frontend;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 60000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  pin_i = '0;
   logic        trig_edge_i = 1'b0;
   logic        chan_en_i = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic [31:0] cfg_wdata_i = '0;
   logic [31:0] cfg_rdata_o;
   logic        cap_stb_o;
   logic [1:0]  ch_mode_o;

   int compared = 0;
   int mismatched = 0;
   int stb_total = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   capchan_frontend dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin_i),
      .trig_edge_i (trig_edge_i),
      .chan_en_i   (chan_en_i),
      .cfg_we_i    (cfg_we_i),
      .cfg_wdata_i (cfg_wdata_i),
      .cfg_rdata_o (cfg_rdata_o),
      .cap_stb_o   (cap_stb_o),
      .ch_mode_o   (ch_mode_o)
   );

   // behavioural reference model
   bit [2:0] pin_q[$];
   bit       m_src;
   int       m_psc;
   int       m_mode;
   bit       m_prev;
   int       m_cnt;
   bit       m_stb;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q = {3'b000, 3'b000};
         m_src = 0; m_psc = 0; m_mode = 0; m_prev = 0; m_cnt = 0; m_stb = 0;
      end else begin
         bit [2:0] seen;
         bit       own, s, rise, act;
         int       lim;
         seen = pin_q[0];
         own  = m_src ? (seen[0] ^ seen[1] ^ seen[2]) : seen[0];
         case (m_mode)
            1: s = own;
            2: s = seen[1];
            3: s = trig_edge_i;
            default: s = 0;
         endcase
         rise = s && !m_prev;
         act  = chan_en_i && (m_mode != 0);
         lim  = (1 << m_psc) - 1;
         m_stb = act && rise && (m_cnt >= lim);
         if (!chan_en_i) m_cnt = 0;
         else if (act && rise) m_cnt = (m_cnt >= lim) ? 0 : m_cnt + 1;
         m_prev = s;
         void'(pin_q.pop_front());
         pin_q.push_back(pin_i);
         if (cfg_we_i) begin
            m_src = cfg_wdata_i[31];
            m_psc = int'(cfg_wdata_i[19:18]);
            if (!chan_en_i) m_mode = int'(cfg_wdata_i[17:16]);
         end
      end
   end

   function automatic logic [31:0] model_rdata();
      logic [31:0] r;
      r = '0;
      r[31] = m_src;
      r[19:18] = 2'(m_psc);
      r[17:16] = 2'(m_mode);
      return r;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check("R5/R10 strobe vs model", 32'(cap_stb_o), 32'(m_stb));
         check("R8 mode output vs model", 32'(ch_mode_o), 32'(m_mode));
         check("R2 read-back vs model", cfg_rdata_o, model_rdata());
         if (cap_stb_o) stb_total++;
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         mismatched++;
         $display("FAIL watchdog (all requirements) actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
         summary();
         $finish;
      end
   end

   task automatic wr(logic [31:0] v);
      @(negedge clk); cfg_we_i = 1'b1; cfg_wdata_i = v;
      @(negedge clk); cfg_we_i = 1'b0;
   endtask

   task automatic set_en(bit v);
      @(negedge clk); chan_en_i = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse(logic [2:0] mask, bit trig, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); pin_i = mask; trig_edge_i = trig;
         repeat (4) @(negedge clk);
         pin_i = '0; trig_edge_i = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic expect_stb(string tag, int base, int exp);
      @(negedge clk);
      check(tag, 32'(stb_total - base), 32'(exp));
   endtask

   initial begin
      int b;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 rdata at reset", cfg_rdata_o, 32'h0);
      check("R1 mode at reset", 32'(ch_mode_o), 32'h0);
      check("R1 strobe at reset", 32'(cap_stb_o), 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 reserved bits
      wr(32'hFFFF_FFFF);
      check("R2 only stored fields read back", cfg_rdata_o, 32'h800F_0000);

      // R3 own pin source
      wr(32'h0001_0000);
      set_en(1);
      b = stb_total; pulse(3'b001, 0, 4); expect_stb("R3 pin0 events", b, 4);
      b = stb_total; pulse(3'b110, 0, 3); expect_stb("R3 pins 1,2 ignored", b, 0);

      // R11 latency through synchronizer
      @(negedge clk); pin_i = 3'b001;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         check($sformatf("R11 latency sample %0d", k), 32'(cap_stb_o), 32'(k == 3));
      end
      pin_i = '0; repeat (4) @(negedge clk);

      // R4 XOR source
      wr(32'h8001_0000);
      b = stb_total; pulse(3'b100, 0, 3); expect_stb("R4 xor via pin2", b, 3);
      b = stb_total; pulse(3'b010, 0, 2); expect_stb("R4 xor via pin1", b, 2);
      b = stb_total; pulse(3'b111, 0, 2); expect_stb("R4 xor of all three", b, 2);

      // R5 prescale codes
      for (int p = 1; p < 4; p++) begin
         wr(32'h0001_0000 | (32'(p) << 18));
         b = stb_total; pulse(3'b001, 0, 16);
         expect_stb($sformatf("R5 prescale code %0d", p), b, 16 >> p);
      end

      // R6 clear on disable (code 11 still set)
      pulse(3'b001, 0, 5);
      set_en(0);
      set_en(1);
      b = stb_total; pulse(3'b001, 0, 3); expect_stb("R6 count cleared", b, 0);
      b = stb_total; pulse(3'b001, 0, 5); expect_stb("R6 eighth event after clear", b, 1);

      // R7 mode write protection
      wr(32'h0002_0000);
      check("R7 mode kept in rdata", cfg_rdata_o, 32'h0001_0000);
      check("R7 mode output kept", 32'(ch_mode_o), 32'h1);

      // R8 neighbour pin and trigger selection
      set_en(0); wr(32'h0002_0000); set_en(1);
      check("R8 mode 10 readable", 32'(ch_mode_o), 32'h2);
      b = stb_total; pulse(3'b010, 0, 3); expect_stb("R8 pin1 selected", b, 3);
      b = stb_total; pulse(3'b001, 0, 2); expect_stb("R8 pin0 not selected", b, 0);
      set_en(0); wr(32'h0003_0000); set_en(1);
      b = stb_total; pulse(3'b000, 1, 2); expect_stb("R8 trigger edge", b, 2);

      // R9 idle conditions
      set_en(0);
      b = stb_total; pulse(3'b000, 1, 2); expect_stb("R9 disabled", b, 0);
      wr(32'h0000_0000); set_en(1);
      b = stb_total; pulse(3'b111, 1, 2); expect_stb("R9 output mode", b, 0);

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end
endmodule